// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block steps a system through a clock speed change. Software picks one of three speeds (full, half or one thirty-second) by writing a one-hot pattern to a control register. When the write turns on exactly one speed bit that was off before, the sequencer latches the chosen speed and pulls the active-low freeze line. It then waits, for as long as it takes, until the rest of the system acknowledges the freeze.

After the acknowledge it runs four timed phases, each set by its own delay register:
- the wait before the active-low clock-change strobes go low,
- the wait before PLL bypass is raised,
- the wait before the strobes are released,
- the settle wait before freeze and bypass are released together.

All counts are in block clock cycles. Software is expected to clear the control register a short while after setting it. A busy flag can be read while a sequence runs, and trigger writes made during that time are ignored.

Top module: `freq_change_seq`

## Requirements
- R1: After reset `freeze_n` is 1, every `clk_chg_n` bit is 1, `pll_bypass` is 0, `busy` is 0, `freq_sel` is 0 and every register reads 0.
- R2: The speed bits are control bits 0 (full), 1 (half) and 5 (1/32). A control write (address 0) made while idle whose speed bits have exactly one bit set, that bit having been 0 in the stored control value, starts a sequence. After the write's clock edge, `freeze_n` is 0, `busy` is 1, and `freq_sel` holds that bit as {bit5, bit1, bit0}.
- R3: A control write with zero, two or three speed bits set starts nothing, whatever reserved bits 2 to 4 hold.
- R4: A control write whose single speed bit was already 1 in the stored value starts nothing.
- R5: While waiting for `freeze_ack`, `freeze_n` stays 0 and the strobes stay high, for any length of wait.
- R6: All `clk_chg_n` bits fall together at the (A+2)th clock edge, counting as the first edge the one that samples `freeze_ack` high; A is the assert-change delay at address 1.
- R7: `pll_bypass` rises B+1 edges after the strobes fall; B is the bypass delay at address 2.
- R8: The strobes return high C+1 edges after `pll_bypass` rises, while bypass and freeze stay asserted; C is the release delay at address 3.
- R9: D+1 edges after the strobes return high, `freeze_n` returns to 1 and, on the same edge, `pll_bypass` and `busy` return to 0; D is the settle delay at address 4.
- R10: A control write made while busy neither changes `freq_sel` nor starts a further sequence once the current one ends.
- R11: Reads return the control register at address 0, the four delays at addresses 1 to 4 and `busy` in bit 0 at address 5.
- R12: The strobes and `pll_bypass` are asserted only while `freeze_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational |
| freeze_ack | input | 1 | Freeze acknowledge from the system |
| freeze_n | output | 1 | Active-low freeze request |
| clk_chg_n | output | 3 | Active-low clock-change strobes |
| pll_bypass | output | 1 | PLL bypass request |
| busy | output | 1 | Sequence in progress |
| freq_sel | output | 3 | Latched speed choice {1/32, half, full} |

## Verification
The bench sweeps every speed bit against several sets of delays, including zero. It measures each phase length in clock edges, so an off-by-one counter shows up as a phase one cycle too long or too short. Control writes with two bits set, with only reserved bits set, or that repeat a bit already set must leave the freeze line high; a design that triggered on the level instead of the rising bit would start a second sequence. A change of speed written in the middle of a sequence must leave `freq_sel` unchanged and must not queue a follow-on run. A sequencer that loaded a new choice while busy would switch speed mid-handshake.

// File: rtl/freq_change_seq.sv
module freq_change_seq #(
  parameter int DW      = 32,
  parameter int AW      = 3,
  parameter int ACT_W   = 8,
  parameter int BYP_W   = 16,
  parameter int REL_W   = 8,
  parameter int SET_W   = 32,
  parameter int NSTROBE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  input  logic               freeze_ack,
  output logic               freeze_n,
  output logic [NSTROBE-1:0] clk_chg_n,
  output logic               pll_bypass,
  output logic               busy,
  output logic [2:0]         freq_sel
);
  localparam int M1    = (ACT_W > BYP_W) ? ACT_W : BYP_W;
  localparam int M2    = (REL_W > SET_W) ? REL_W : SET_W;
  localparam int CNT_W = (M1 > M2) ? M1 : M2;

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_ACT  = AW'(1);
  localparam logic [AW-1:0] A_BYP  = AW'(2);
  localparam logic [AW-1:0] A_REL  = AW'(3);
  localparam logic [AW-1:0] A_SET  = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ACT, S_BYP, S_REL, S_SET} state_t;

  state_t           state;
  logic [DW-1:0]    ctrl;
  logic [ACT_W-1:0] t_act;
  logic [BYP_W-1:0] t_byp;
  logic [REL_W-1:0] t_rel;
  logic [SET_W-1:0] t_set;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       spd_new, spd_old;
  logic             one_hot, go, expire;

  assign spd_new = {wr_data[5], wr_data[1], wr_data[0]};
  assign spd_old = {ctrl[5], ctrl[1], ctrl[0]};
  assign one_hot = (spd_new == 3'b001) || (spd_new == 3'b010) || (spd_new == 3'b100);
  assign go      = wr_en && (wr_addr == A_CTRL) && (state == S_IDLE) && one_hot
                   && ((spd_new & ~spd_old) != 3'b000);
  assign expire  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      t_act <= '0;
      t_byp <= '0;
      t_rel <= '0;
      t_set <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl  <= wr_data;
        A_ACT:   t_act <= wr_data[ACT_W-1:0];
        A_BYP:   t_byp <= wr_data[BYP_W-1:0];
        A_REL:   t_rel <= wr_data[REL_W-1:0];
        A_SET:   t_set <= wr_data[SET_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      freq_sel <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state    <= S_WAIT;
          freq_sel <= spd_new;
        end
        S_WAIT: if (freeze_ack) begin
          state <= S_ACT;
          cnt   <= CNT_W'(t_act);
        end
        S_ACT: if (expire) begin
          state <= S_BYP;
          cnt   <= CNT_W'(t_byp);
        end else cnt <= cnt - 1'b1;
        S_BYP: if (expire) begin
          state <= S_REL;
          cnt   <= CNT_W'(t_rel);
        end else cnt <= cnt - 1'b1;
        S_REL: if (expire) begin
          state <= S_SET;
          cnt   <= CNT_W'(t_set);
        end else cnt <= cnt - 1'b1;
        S_SET: if (expire) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign freeze_n   = !busy;
  assign clk_chg_n  = {NSTROBE{!((state == S_BYP) || (state == S_REL))}};
  assign pll_bypass = (state == S_REL) || (state == S_SET);

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl;
      A_ACT:   rd_data = DW'(t_act);
      A_BYP:   rd_data = DW'(t_byp);
      A_REL:   rd_data = DW'(t_rel);
      A_SET:   rd_data = DW'(t_set);
      A_STAT:  rd_data = DW'(busy);
      default: rd_data = '0;
    endcase
  end
endmodule

module fcs_checker #(
  parameter int AW = 3,
  parameter int NS = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          freeze_n,
  input logic [NS-1:0] clk_chg_n,
  input logic          pll_bypass,
  input logic          busy,
  input logic [2:0]    freq_sel
);
  // R12
  outputs_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_n |-> (clk_chg_n == '1 && !pll_bypass));
  // R2
  freeze_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freeze_n) |-> ($past(wr_en) && $past(wr_addr) == '0 && busy && $countones(freq_sel) == 1));
  // R6
  strobes_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(clk_chg_n) == 0) || ($countones(clk_chg_n) == NS));
  // R7
  bypass_after_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_bypass) |-> (clk_chg_n == '0 && !freeze_n));
  // R8
  chg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_chg_n[0]) |-> (pll_bypass && !freeze_n));
  // R9
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_n) |-> (!busy && !pll_bypass && $past(pll_bypass)));
  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(freq_sel));
endmodule

bind freq_change_seq fcs_checker #(.AW(AW), .NS(NSTROBE)) u_fcs_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .freeze_n(freeze_n), .clk_chg_n(clk_chg_n), .pll_bypass(pll_bypass),
  .busy(busy), .freq_sel(freq_sel)
);

// File: tb/test_freq_change_seq.sv
module test_freq_change_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        freeze_ack = 1'b0;
  logic        freeze_n;
  logic [2:0]  clk_chg_n;
  logic        pll_bypass;
  logic        busy;
  logic [2:0]  freq_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  freq_change_seq i_freq_change_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .freeze_ack(freeze_ack),
    .freeze_n(freeze_n), .clk_chg_n(clk_chg_n), .pll_bypass(pll_bypass),
    .busy(busy), .freq_sel(freq_sel)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_edges(input int which, output int n);
    bit hit;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      case (which)
        0: hit = (clk_chg_n == 3'b000);
        1: hit = pll_bypass;
        2: hit = (clk_chg_n == 3'b111);
        default: hit = freeze_n;
      endcase
    end while (!hit && n < 400);
  endtask

  task automatic expect_idle(input string req);
    repeat (3) @(negedge clk);
    chk(freeze_n && !busy && clk_chg_n == 3'b111 && !pll_bypass, req,
        {busy, freeze_n}, 2'b01);
  endtask

  task automatic run_seq(input int s, input int a, input int b, input int c, input int d);
    logic [31:0] v;
    int n;
    wr(0, 0); wr(1, a); wr(2, b); wr(3, c); wr(4, d);
    rd(1, v); chk(v == a, "R11 act readback", v, a);
    rd(4, v); chk(v == d, "R11 settle readback", v, d);
    wr(0, (s == 2) ? 32'h20 : (32'h1 << s));
    chk(!freeze_n && busy, "R2 freeze on trigger", {busy, freeze_n}, 2'b10);
    chk(freq_sel == (3'b001 << s), "R2 freq_sel", freq_sel, 3'b001 << s);
    repeat (4 + s) @(negedge clk);
    chk(!freeze_n && clk_chg_n == 3'b111 && !pll_bypass, "R5 waiting for ack",
        clk_chg_n, 3'b111);
    rd(5, v); chk(v == 1, "R11 busy status", v, 1);
    @(negedge clk); freeze_ack = 1'b1;
    wait_edges(0, n); chk(n == a + 2, "R6 ack to strobes", n, a + 2);
    wait_edges(1, n); chk(n == b + 1, "R7 strobes to bypass", n, b + 1);
    chk(!freeze_n, "R7 freeze held", freeze_n, 0);
    wait_edges(2, n); chk(n == c + 1, "R8 bypass to release", n, c + 1);
    chk(pll_bypass && !freeze_n, "R8 bypass held", pll_bypass, 1);
    wait_edges(3, n); chk(n == d + 1, "R9 settle", n, d + 1);
    chk(!pll_bypass && !busy, "R9 release", {pll_bypass, busy}, 0);
    @(negedge clk); freeze_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk(freeze_n && clk_chg_n == 3'b111 && !pll_bypass && !busy && freq_sel == 0,
        "R1 outputs", {freeze_n, clk_chg_n, pll_bypass, busy}, 6'b111100);
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      chk(v == 0, "R1 register", v, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 4; k++)
        run_seq(s, k, (k * 2) % 5, 3 - k, k * 3 + 1);

    // R3 multi-bit and reserved-only writes
    wr(0, 0); wr(0, 32'h3);  expect_idle("R3 two bits");
    wr(0, 0); wr(0, 32'h21); expect_idle("R3 bits 0 and 5");
    wr(0, 0); wr(0, 32'h23); expect_idle("R3 three bits");
    wr(0, 0); wr(0, 32'h1C); expect_idle("R3 reserved only");
    rd(0, v); chk(v == 32'h1C, "R11 ctrl readback", v, 32'h1C);

    // R10 write while busy
    wr(1, 0); wr(2, 1); wr(3, 1); wr(4, 2);
    wr(0, 0); wr(0, 32'h1);
    wr(0, 0); wr(0, 32'h2);
    chk(freq_sel == 3'b001, "R10 sel held", freq_sel, 3'b001);
    @(negedge clk); freeze_ack = 1'b1;
    begin
      int n;
      wait_edges(3, n);
      chk(n == 2 + 2 + 2 + 3 - 1 + 1, "R10 sequence unchanged", n, 9);
    end
    @(negedge clk); freeze_ack = 1'b0;
    expect_idle("R10 no follow-on");
    chk(freq_sel == 3'b001, "R10 sel after", freq_sel, 3'b001);

    // R4 speed bit already set
    wr(0, 32'h2); expect_idle("R4 no rise");
    wr(0, 32'h22); expect_idle("R4 partial rise multi");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule